// File: doc/BRIEF.md
# Indirect Pointer Address Generator

This block forms data-memory addresses for load and store operations. It keeps three 16-bit pointer registers, X, Y and Z. A command selects an addressing mode and, where the mode needs one, a pointer. The block then presents the effective address and, one cycle later, a read or write strobe. Post-increment and pre-decrement commands write the updated pointer back. Displacement commands add a small unsigned offset to Y or Z and leave the pointer unchanged. Direct commands take a 16-bit immediate as the address and touch no pointer.

An accepted command occupies the block for two cycles, and `busy` is high for both. The address is registered at acceptance and stays on `mem_addr` for both cycles. The strobe is issued in the second cycle. A dedicated load port lets the surrounding core write any pointer at any time. A command the block cannot carry out is rejected with a one-cycle `cmd_illegal` pulse and causes no memory access.

Top module: `ptr_agu`

## Requirements
- R1: After reset all three pointers read as 0, and `busy`, `mem_rd`, `mem_wr` and `cmd_illegal` are low.
- R2: A cycle with `ld_en` high writes `ld_data` into the pointer chosen by `ld_sel`. The pointer codes are X=0, Y=1 and Z=2; code 3 writes nothing.
- R3: Plain mode (`cmd_mode`=0) uses the selected pointer as the address and leaves it unchanged.
- R4: Post-increment mode (`cmd_mode`=1) uses the current pointer as the address. The pointer then becomes pointer+1 modulo 2^16.
- R5: Pre-decrement mode (`cmd_mode`=2) uses pointer−1 modulo 2^16 as the address, and that value becomes the new pointer.
- R6: Displacement mode (`cmd_mode`=3) on Y or Z uses pointer + zero-extended 6-bit `cmd_disp`, modulo 2^16, as the address. The pointer is left unchanged.
- R7: Direct mode (`cmd_mode`=4) uses `cmd_imm` as the address whatever `cmd_ptr` is, and changes no pointer.
- R8: A command accepted at a clock edge (`cmd_valid` high, `busy` low) drives its address on `mem_addr` for the next two cycles, and `busy` is high for exactly those two cycles. Exactly one strobe pulses, in the second cycle only: `mem_wr` if `cmd_write`=1, otherwise `mem_rd`. The two strobes are never high together.
- R9: The following commands raise `cmd_illegal` for one cycle, with no `busy`, no strobe and no pointer change:
  - displacement mode with X selected;
  - `cmd_mode` codes 5 to 7;
  - an indirect mode with `cmd_ptr`=3.
- R10: `cmd_valid` is ignored while `busy` is high.
- R11: When a write-back and a load-port write target the same pointer at the same edge, the write-back wins. A load to a different pointer at that edge still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_mode | input | 3 | Addressing mode code |
| cmd_ptr | input | 2 | Pointer select (X=0, Y=1, Z=2) |
| cmd_write | input | 1 | 1 = store, 0 = load |
| cmd_disp | input | 6 | Unsigned displacement |
| cmd_imm | input | 16 | Direct address |
| ld_en | input | 1 | Pointer load enable |
| ld_sel | input | 2 | Pointer to load |
| ld_data | input | 16 | Pointer load value |
| mem_addr | output | 16 | Effective address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| busy | output | 1 | Operation in progress |
| cmd_illegal | output | 1 | Rejected-command pulse |

## Verification
The bench builds the block with its default widths: 16-bit pointers and a 6-bit displacement. At these widths the wrap points 0x0000 and 0xFFFF are direct test values, so increment and decrement wrapping can be checked without long runs. The displacement is swept over all 64 offsets on Y and Z, starting from pointers near the top of the address space, which covers every carry out of the addition. Every mode is run on every pointer with both load and store strobes. Pointer contents are read back through plain-mode commands.

// File: rtl/ptr_agu_pkg.sv
package ptr_agu_pkg;

    localparam int NPTR = 3;
    localparam int SELW = 2;

    typedef enum logic [2:0] {
        MODE_PLAIN   = 3'd0,
        MODE_POSTINC = 3'd1,
        MODE_PREDEC  = 3'd2,
        MODE_DISP    = 3'd3,
        MODE_DIRECT  = 3'd4
    } agu_mode_e;

    typedef enum logic [1:0] {
        PSEL_X = 2'd0,
        PSEL_Y = 2'd1,
        PSEL_Z = 2'd2
    } agu_psel_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_XFER = 2'd2
    } agu_phase_e;

endpackage

// File: rtl/ptr_agu_ptrfile.sv
module ptr_agu_ptrfile
    import ptr_agu_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_en,
    input  logic [SELW-1:0]      ld_sel,
    input  logic [AW-1:0]        ld_data,
    input  logic                 wb_en,
    input  logic [SELW-1:0]      wb_sel,
    input  logic [AW-1:0]        wb_data,
    output logic [NPTR*AW-1:0]   ptr_flat
);

    logic [AW-1:0] ptr_d [NPTR];
    logic [AW-1:0] ptr_q [NPTR];

    for (genvar i = 0; i < NPTR; i++) begin : g_ptr
        localparam logic [SELW-1:0] MY_SEL = SELW'(i);

        always_comb begin
            ptr_d[i] = ptr_q[i];
            if (ld_en && ld_sel == MY_SEL) begin
                ptr_d[i] = ld_data;
            end
            // write-back has priority over the load port (R11)
            if (wb_en && wb_sel == MY_SEL) begin
                ptr_d[i] = wb_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ptr_q[i] <= '0;
            end else begin
                ptr_q[i] <= ptr_d[i];
            end
        end

        assign ptr_flat[i*AW +: AW] = ptr_q[i];
    end

endmodule

// File: rtl/ptr_agu_ea.sv
module ptr_agu_ea
    import ptr_agu_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 6
) (
    input  logic [2:0]       mode,
    input  logic [SELW-1:0]  sel,
    input  logic [AW-1:0]    base,
    input  logic [DW-1:0]    disp,
    input  logic [AW-1:0]    imm,
    output logic [AW-1:0]    ea,
    output logic [AW-1:0]    upd_val,
    output logic             upd_need,
    output logic             legal
);

    logic [AW-1:0] disp_ext;
    logic          ptr_ok;

    if (DW < AW) begin : g_zext
        assign disp_ext = {{(AW-DW){1'b0}}, disp};
    end else begin : g_trunc
        assign disp_ext = disp[AW-1:0];
    end

    assign ptr_ok = (int'(sel) < NPTR);

    always_comb begin
        ea       = base;
        upd_val  = base;
        upd_need = 1'b0;
        legal    = 1'b0;
        case (mode)
            MODE_PLAIN: begin
                legal = ptr_ok;
            end
            MODE_POSTINC: begin
                upd_val  = base + AW'(1);
                upd_need = 1'b1;
                legal    = ptr_ok;
            end
            MODE_PREDEC: begin
                ea       = base - AW'(1);
                upd_val  = base - AW'(1);
                upd_need = 1'b1;
                legal    = ptr_ok;
            end
            MODE_DISP: begin
                ea    = base + disp_ext;
                legal = ptr_ok && (sel != PSEL_X);
            end
            MODE_DIRECT: begin
                ea    = imm;
                legal = 1'b1;
            end
            default: begin
                legal = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ptr_agu_seq.sv
module ptr_agu_seq
    import ptr_agu_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [SELW-1:0]      cmd_ptr,
    input  logic                 cmd_write,
    input  logic [AW-1:0]        ea,
    input  logic [AW-1:0]        upd_val,
    input  logic                 upd_need,
    input  logic                 legal,
    output logic [AW-1:0]        mem_addr,
    output logic                 mem_rd,
    output logic                 mem_wr,
    output logic                 busy,
    output logic                 cmd_illegal,
    output logic                 wb_en,
    output logic [SELW-1:0]      wb_sel,
    output logic [AW-1:0]        wb_data
);

    typedef struct packed {
        agu_phase_e        phase;
        logic [AW-1:0]     addr;
        logic [AW-1:0]     upd;
        logic [SELW-1:0]   upd_sel;
        logic              upd_need;
        logic              is_wr;
        logic              strobe;
        logic              illegal;
    } seq_s;

    seq_s st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.strobe  = 1'b0;
        st_d.illegal = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (cmd_valid) begin
                    if (legal) begin
                        st_d.phase    = PH_ADDR;
                        st_d.addr     = ea;
                        st_d.upd      = upd_val;
                        st_d.upd_sel  = cmd_ptr;
                        st_d.upd_need = upd_need;
                        st_d.is_wr    = cmd_write;
                    end else begin
                        st_d.illegal  = 1'b1;
                    end
                end
            end
            PH_ADDR: begin
                st_d.phase  = PH_XFER;
                st_d.strobe = 1'b1;
            end
            PH_XFER: begin
                st_d.phase    = PH_IDLE;
                st_d.upd_need = 1'b0;
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_addr    = st_q.addr;
    assign busy        = (st_q.phase != PH_IDLE);
    assign mem_rd      = st_q.strobe && !st_q.is_wr;
    assign mem_wr      = st_q.strobe && st_q.is_wr;
    assign cmd_illegal = st_q.illegal;
    assign wb_en       = (st_q.phase == PH_ADDR) && st_q.upd_need;
    assign wb_sel      = st_q.upd_sel;
    assign wb_data     = st_q.upd;

endmodule

// File: rtl/ptr_agu.sv
module ptr_agu
    import ptr_agu_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_mode,
    input  logic [1:0]        cmd_ptr,
    input  logic              cmd_write,
    input  logic [DW-1:0]     cmd_disp,
    input  logic [AW-1:0]     cmd_imm,
    input  logic              ld_en,
    input  logic [1:0]        ld_sel,
    input  logic [AW-1:0]     ld_data,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              busy,
    output logic              cmd_illegal
);

    logic [NPTR*AW-1:0] ptr_flat;
    logic [AW-1:0]      base;
    logic [AW-1:0]      ea;
    logic [AW-1:0]      upd_val;
    logic               upd_need;
    logic               legal;
    logic               wb_en;
    logic [SELW-1:0]    wb_sel;
    logic [AW-1:0]      wb_data;

    always_comb begin
        base = '0;
        for (int i = 0; i < NPTR; i++) begin
            if (cmd_ptr == SELW'(i)) begin
                base = ptr_flat[i*AW +: AW];
            end
        end
    end

    ptr_agu_ptrfile #(.AW(AW)) u_ptrfile (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_en    (ld_en),
        .ld_sel   (ld_sel),
        .ld_data  (ld_data),
        .wb_en    (wb_en),
        .wb_sel   (wb_sel),
        .wb_data  (wb_data),
        .ptr_flat (ptr_flat)
    );

    ptr_agu_ea #(.AW(AW), .DW(DW)) u_ea (
        .mode     (cmd_mode),
        .sel      (cmd_ptr),
        .base     (base),
        .disp     (cmd_disp),
        .imm      (cmd_imm),
        .ea       (ea),
        .upd_val  (upd_val),
        .upd_need (upd_need),
        .legal    (legal)
    );

    ptr_agu_seq #(.AW(AW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_ptr     (cmd_ptr),
        .cmd_write   (cmd_write),
        .ea          (ea),
        .upd_val     (upd_val),
        .upd_need    (upd_need),
        .legal       (legal),
        .mem_addr    (mem_addr),
        .mem_rd      (mem_rd),
        .mem_wr      (mem_wr),
        .busy        (busy),
        .cmd_illegal (cmd_illegal),
        .wb_en       (wb_en),
        .wb_sel      (wb_sel),
        .wb_data     (wb_data)
    );

endmodule

// File: rtl/ptr_agu_chk.sv
module ptr_agu_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          busy,
    input logic          cmd_illegal
);

    assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_strobe_in_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> busy);

    assert_strobe_second_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> (busy && (mem_rd || mem_wr)));

    assert_op_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |=> !busy);

    assert_addr_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> $stable(mem_addr));

    assert_illegal_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_illegal |-> (!busy && !mem_rd && !mem_wr));

    assert_illegal_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_illegal && !cmd_valid) |=> !cmd_illegal);

    assert_busy_no_reject_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !cmd_illegal);

endmodule

bind ptr_agu ptr_agu_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .mem_addr    (mem_addr),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .busy        (busy),
    .cmd_illegal (cmd_illegal)
);

// File: tb/sim_ptr_agu.sv
`timescale 1ns/1ps
module sim_ptr_agu;

    localparam int AW = 16;
    localparam int DW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_mode = '0;
    logic [1:0]    cmd_ptr = '0;
    logic          cmd_write = 1'b0;
    logic [DW-1:0] cmd_disp = '0;
    logic [AW-1:0] cmd_imm = '0;
    logic          ld_en = 1'b0;
    logic [1:0]    ld_sel = '0;
    logic [AW-1:0] ld_data = '0;
    logic [AW-1:0] mem_addr;
    logic          mem_rd, mem_wr, busy, cmd_illegal;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [AW-1:0] model [3];

    always #5 clk = ~clk;

    ptr_agu #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
        .cmd_ptr(cmd_ptr), .cmd_write(cmd_write), .cmd_disp(cmd_disp),
        .cmd_imm(cmd_imm), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .busy(busy),
        .cmd_illegal(cmd_illegal)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic load_ptr(input int sel, input logic [AW-1:0] val);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = 2'(sel); ld_data = val;
        @(negedge clk);
        ld_en = 1'b0;
        if (sel < 3) model[sel] = val;
    endtask

    // issue one legal command, check timing and address, return to idle
    task automatic run_op(input string req, input int mode, input int sel,
                          input bit wr, input int disp, input logic [AW-1:0] imm,
                          input logic [AW-1:0] exp_addr);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_mode = 3'(mode); cmd_ptr = 2'(sel);
        cmd_write = wr; cmd_disp = DW'(disp); cmd_imm = imm;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(req, "addr cycle1", 32'(mem_addr), 32'(exp_addr));
        chk("R8", "cycle1 busy/rd/wr", {busy, mem_rd, mem_wr}, 3'b100);
        @(negedge clk);
        chk("R8", "cycle2 addr", 32'(mem_addr), 32'(exp_addr));
        chk("R8", "cycle2 busy/rd/wr", {busy, mem_rd, mem_wr}, {1'b1, !wr, wr});
        @(negedge clk);
        chk("R8", "after busy/rd/wr", {busy, mem_rd, mem_wr}, 3'b000);
    endtask

    task automatic readback(input string req, input int sel);
        run_op(req, 0, sel, 1'b0, 0, '0, model[sel]);
    endtask

    task automatic illegal_op(input string req, input int mode, input int sel);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_mode = 3'(mode); cmd_ptr = 2'(sel); cmd_write = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(req, "illegal cycle1 ill/busy/rd/wr",
            {cmd_illegal, busy, mem_rd, mem_wr}, 4'b1000);
        @(negedge clk);
        chk(req, "illegal cycle2 ill/busy/rd/wr",
            {cmd_illegal, busy, mem_rd, mem_wr}, 4'b0000);
    endtask

    initial begin
        logic [AW-1:0] vals [7];
        vals = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'hFFC1, 16'h1234};
        for (int i = 0; i < 3; i++) model[i] = '0;

        repeat (3) @(negedge clk);
        chk("R1", "reset busy/rd/wr/ill", {busy, mem_rd, mem_wr, cmd_illegal}, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        for (int s = 0; s < 3; s++) readback("R1", s);

        // R2, R3, R4, R5 sweep over pointers and values
        for (int s = 0; s < 3; s++) begin
            for (int v = 0; v < 7; v++) begin
                load_ptr(s, vals[v]);
                readback("R2", s);
                run_op("R3", 0, s, v[0], 0, '0, model[s]);
                readback("R3", s);
                run_op("R4", 1, s, v[1], 0, '0, model[s]);
                model[s] = model[s] + 1'b1;
                readback("R4", s);
                run_op("R5", 2, s, !v[1], 0, '0, model[s] - 1'b1);
                model[s] = model[s] - 1'b1;
                run_op("R5", 2, s, v[0], 0, '0, model[s] - 1'b1);
                model[s] = model[s] - 1'b1;
                readback("R5", s);
            end
        end
        // R2: code 3 loads nothing
        load_ptr(3, 16'hBEEF);
        for (int s = 0; s < 3; s++) readback("R2", s);

        // R6 displacement sweep on Y and Z
        for (int s = 1; s < 3; s++) begin
            for (int v = 0; v < 3; v++) begin
                load_ptr(s, (v == 0) ? 16'h0000 : (v == 1) ? 16'hFFC0 : 16'hFFFF);
                for (int q = 0; q < 64; q++) begin
                    run_op("R6", 3, s, q[0], q, '0, model[s] + AW'(q));
                end
                readback("R6", s);
            end
        end

        // R7 direct mode, any pointer code, pointers unchanged
        load_ptr(0, 16'h1111); load_ptr(1, 16'h2222); load_ptr(2, 16'h3333);
        for (int s = 0; s < 4; s++) begin
            run_op("R7", 4, s, s[0], 0, 16'hA5C3 ^ AW'(s), 16'hA5C3 ^ AW'(s));
        end
        for (int s = 0; s < 3; s++) readback("R7", s);

        // R9 illegal commands
        illegal_op("R9", 3, 0);
        illegal_op("R9", 5, 1);
        illegal_op("R9", 6, 2);
        illegal_op("R9", 7, 0);
        illegal_op("R9", 1, 3);
        illegal_op("R9", 2, 3);
        for (int s = 0; s < 3; s++) readback("R9", s);

        // R10 command during busy is ignored
        @(negedge clk);
        cmd_valid = 1'b1; cmd_mode = 3'd1; cmd_ptr = 2'd0; cmd_write = 1'b0;
        @(negedge clk);
        cmd_ptr = 2'd1; cmd_mode = 3'd2; cmd_write = 1'b1;  // still valid while busy
        chk("R10", "addr of accepted op", 32'(mem_addr), 32'(model[0]));
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R10", "strobe of accepted op", {busy, mem_rd, mem_wr}, 3'b110);
        chk("R10", "no illegal", 32'(cmd_illegal), 32'd0);
        @(negedge clk);
        chk("R10", "idle after op", {busy, mem_rd, mem_wr}, 3'b000);
        model[0] = model[0] + 1'b1;
        readback("R10", 0);
        readback("R10", 1);

        // R11 write-back beats load on same pointer
        @(negedge clk);
        cmd_valid = 1'b1; cmd_mode = 3'd1; cmd_ptr = 2'd0; cmd_write = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        ld_en = 1'b1; ld_sel = 2'd0; ld_data = 16'h5A5A;
        @(negedge clk);
        ld_en = 1'b0;
        @(negedge clk);
        model[0] = model[0] + 1'b1;
        readback("R11", 0);
        // R11 load to another pointer during write-back still applies
        @(negedge clk);
        cmd_valid = 1'b1; cmd_mode = 3'd2; cmd_ptr = 2'd2; cmd_write = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0;
        ld_en = 1'b1; ld_sel = 2'd1; ld_data = 16'hC0DE;
        @(negedge clk);
        ld_en = 1'b0;
        @(negedge clk);
        model[2] = model[2] - 1'b1;
        model[1] = 16'hC0DE;
        readback("R11", 1);
        readback("R11", 2);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule